// File: doc/BRIEF.md
# Programmable Watchdog Timer

This block is a watchdog timer reached through a small register bus. Software selects one of sixteen timeout lengths, each a power of two in clock cycles, turns the counter on through a control register, and from then on must write an exact restart code at a fixed interval. If the restart code does not arrive in time, the counter reaches zero and the block raises a timeout request that a reset controller can act on. The live count can be read at any time, so software can see how much time is left.

Once the counter has been turned on it cannot be turned off again short of a hardware reset. A new timeout length written while the counter runs is stored but only used at the next reload, which is either the first enable or a restart. The timeout request stays high until a correct restart or a reset, and the counter stays at zero instead of wrapping.

Requests use a valid/ready channel. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. Each accepted read produces exactly one response on the valid/ready response channel, and writes produce none. The block holds one response. While that response waits with `rsp_ready` low, `req_ready` stays low and the response data does not change. The response is taken on an edge where `rsp_valid` and `rsp_ready` are both high.

Top module: `wdog_timer`

## Requirements
- R1: After reset the enable is 0, the stored timeout selection is 0, the count reads 0 and `timeout_o` is low.
- R2: A write with bit 0 set to offset 0x00 while disabled sets the enable. In the same edge it loads the counter with 2^(BASE_EXP+n), where n is the stored selection. A read of offset 0x00 returns the enable in bit 0, with zeros above it.
- R3: Writing 0 to bit 0 of offset 0x00 after the enable is set leaves the enable at 1 and the counter running.
- R4: While enabled and nonzero, the counter drops by one on every clock edge. A read of offset 0x08 returns the count as it stood just before the edge that accepted the read.
- R5: A write to offset 0x04 stores only its low 4 bits, and a read returns them with zeros above. The new selection is used only at the next reload and does not change a countdown in progress.
- R6: A write of exactly 0x00000076 to offset 0x0C while enabled reloads the counter to 2^(BASE_EXP+n) for the stored n, and clears `timeout_o` after that edge.
- R7: A write to offset 0x0C of any other value is ignored, and so is any write there while disabled. While disabled the count stays 0.
- R8: When the enabled counter reaches 0, `timeout_o` goes high and stays high. The count stays at 0 until a valid restart.
- R9: Reads of offset 0x0C and of any offset other than 0x00, 0x04 and 0x08 return 0. Writes to offsets other than 0x00, 0x04 and 0x0C change nothing.
- R10: `req_ready` is low exactly while a response is held with `rsp_ready` low. A held response keeps its data. Each accepted read yields one response and each write yields none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Consumer takes the read data |
| rsp_rdata | output | DATA_W | Read data |
| timeout_o | output | 1 | Timeout request, high from expiry until a valid restart |

## Verification
The assertions assume that the request fields are meaningful only when `req_valid` is high. They also assume that the restart code and the enable arrive only as accepted writes, with one request at most per edge. The checker rebuilds the restart condition from the request pins and relates it to the counter and `timeout_o`. The stimulus drives every request on a falling edge and holds it until an edge where `req_ready` is high, then drops `req_valid`. It changes `rsp_ready` just after a rising edge, so both channels follow the handshake rules the checker relies on.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam logic [7:0]  OFS_CTRL   = 8'h00;
  localparam logic [7:0]  OFS_RANGE  = 8'h04;
  localparam logic [7:0]  OFS_COUNT  = 8'h08;
  localparam logic [7:0]  OFS_KICK   = 8'h0C;
  localparam logic [31:0] KICK_MAGIC = 32'h0000_0076;

  typedef enum logic [2:0] {
    REG_CTRL,
    REG_RANGE,
    REG_COUNT,
    REG_KICK,
    REG_NONE
  } reg_sel_e;

endpackage

// File: rtl/wdt_bus_port.sv
module wdt_bus_port #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  output logic              req_ready,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [DATA_W-1:0] rd_data,
  output logic              accept
);

  logic              hold_q;
  logic [DATA_W-1:0] data_q;

  // one response slot: taking a new request needs the slot free or draining
  assign req_ready = !hold_q || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      data_q <= '0;
    end else if (accept && !req_write) begin
      hold_q <= 1'b1;
      data_q <= rd_data;
    end else if (rsp_ready) begin
      hold_q <= 1'b0;
    end
  end

  assign rsp_valid = hold_q;
  assign rsp_rdata = data_q;

endmodule

// File: rtl/wdt_regfile.sv
module wdt_regfile
  import wdt_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int SEL_W     = 4,
  parameter int CNT_W     = 32,
  parameter int RESET_SEL = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt,
  output logic              enable,
  output logic [SEL_W-1:0]  sel,
  output logic              load,
  output logic [DATA_W-1:0] rd_data
);

  reg_sel_e         dec;
  logic             en_q;
  logic [SEL_W-1:0] sel_q;
  logic             wr_acc;
  logic             kick_ok;

  always_comb begin
    if (addr == ADDR_W'(OFS_CTRL))       dec = REG_CTRL;
    else if (addr == ADDR_W'(OFS_RANGE)) dec = REG_RANGE;
    else if (addr == ADDR_W'(OFS_COUNT)) dec = REG_COUNT;
    else if (addr == ADDR_W'(OFS_KICK))  dec = REG_KICK;
    else                                 dec = REG_NONE;
  end

  assign wr_acc  = accept && wr;
  assign kick_ok = (wdata == DATA_W'(KICK_MAGIC));

  // enable can only be raised; selection is stored, used at reload
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      sel_q <= SEL_W'(RESET_SEL);
    end else if (wr_acc) begin
      case (dec)
        REG_CTRL:  if (wdata[0]) en_q <= 1'b1;
        REG_RANGE: sel_q <= wdata[SEL_W-1:0];
        default:   ;
      endcase
    end
  end

  assign load = wr_acc &&
                (((dec == REG_CTRL) && wdata[0] && !en_q) ||
                 ((dec == REG_KICK) && kick_ok && en_q));

  always_comb begin
    case (dec)
      REG_CTRL:  rd_data = DATA_W'(en_q);
      REG_RANGE: rd_data = DATA_W'(sel_q);
      REG_COUNT: rd_data = DATA_W'(cnt);
      default:   rd_data = '0;
    endcase
  end

  assign enable = en_q;
  assign sel    = sel_q;

endmodule

// File: rtl/wdt_downcount.sv
module wdt_downcount #(
  parameter int SEL_W    = 4,
  parameter int BASE_EXP = 16,
  parameter int CNT_W    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             load,
  input  logic [SEL_W-1:0] sel,
  output logic [CNT_W-1:0] cnt,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] period;

  assign period = CNT_W'(1) << (BASE_EXP + int'(sel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt_q <= '0;
    else if (load)                    cnt_q <= period;
    else if (enable && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign cnt     = cnt_q;
  assign expired = enable && (cnt_q == '0);

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int SEL_W     = 4,
  parameter int BASE_EXP  = 16,
  parameter int RESET_SEL = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              timeout_o
);

  localparam int NUM_SEL = 1 << SEL_W;
  localparam int CNT_W   = BASE_EXP + NUM_SEL;

  logic              accept;
  logic [DATA_W-1:0] rd_data;
  logic              en_q;
  logic [SEL_W-1:0]  sel_q;
  logic              load;
  logic [CNT_W-1:0]  cnt_q;

  wdt_bus_port #(.DATA_W(DATA_W)) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_ready (req_ready),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rd_data   (rd_data),
    .accept    (accept)
  );

  wdt_regfile #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W),
    .CNT_W(CNT_W), .RESET_SEL(RESET_SEL)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .wr      (req_write),
    .addr    (req_addr),
    .wdata   (req_wdata),
    .cnt     (cnt_q),
    .enable  (en_q),
    .sel     (sel_q),
    .load    (load),
    .rd_data (rd_data)
  );

  wdt_downcount #(
    .SEL_W(SEL_W), .BASE_EXP(BASE_EXP), .CNT_W(CNT_W)
  ) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (en_q),
    .load    (load),
    .sel     (sel_q),
    .cnt     (cnt_q),
    .expired (timeout_o)
  );

endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              timeout_o,
  input logic              en,
  input logic [CNT_W-1:0]  cnt
);

  logic kick;
  assign kick = req_valid && req_ready && req_write &&
                (req_addr == ADDR_W'(OFS_KICK)) &&
                (req_wdata == DATA_W'(KICK_MAGIC));

  assert_enable_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> en);

  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt != '0 && !kick) |=> (cnt == $past(cnt) - 1'b1));

  assert_restart_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && kick) |=> !timeout_o);

  assert_idle_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (cnt == '0 && !timeout_o));

  assert_timeout_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_o && !kick) |=> (timeout_o && cnt == '0));

  assert_rsp_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  assert_no_accept_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

endmodule

bind wdog_timer wdog_timer_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata),
  .timeout_o (timeout_o),
  .en        (en_q),
  .cnt       (cnt_q)
);

// File: tb/wdog_timer_tb_top.sv
`timescale 1ns/1ps
module wdog_timer_tb_top;

  localparam int BASE = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic        timeout_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  // reference state, from the requirements
  bit   en_m = 1'b0;
  int   sel_m = 0;
  int   per_m = 0;
  int   load_edge = 0;

  wdog_timer #(.BASE_EXP(BASE)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .timeout_o(timeout_o)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int cnt_after(int edges);
    int d;
    if (!en_m) return 0;
    d = edges - load_edge;
    if (d >= per_m) return 0;
    return per_m - d;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    int e;
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    e = cyc + 1;
    if (a == 8'h00 && d[0] && !en_m) begin
      en_m = 1'b1; load_edge = e; per_m = 1 << (BASE + sel_m);
    end else if (a == 8'h04) begin
      sel_m = int'(d[3:0]);
    end else if (a == 8'h0C && d == 32'h76 && en_m) begin
      load_edge = e; per_m = 1 << (BASE + sel_m);
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, string tag);
    int e;
    logic [31:0] x;
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    while (!req_ready) @(negedge clk);
    e = cyc + 1;
    case (a)
      8'h00:   x = {31'b0, en_m};
      8'h04:   x = 32'(sel_m);
      8'h08:   x = 32'(cnt_after(e - 1));
      default: x = 32'h0;
    endcase
    exp_q.push_back(x);
    tag_q.push_back(tag);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor: pops the scoreboard when a response is handed over
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R10: actual response %h expected none", rsp_rdata);
      end else begin
        check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 timeout", {31'b0, timeout_o}, 32'h0);
    rd(8'h00, "R1 ctrl");
    rd(8'h04, "R1 range");
    rd(8'h08, "R1 count");
    // R7 restart while disabled
    wr(8'h0C, 32'h76);
    rd(8'h08, "R7 count idle");
    check("R7 timeout idle", {31'b0, timeout_o}, 32'h0);
    // R5 only low bits kept
    wr(8'h04, 32'hFFFF_FFF0);
    rd(8'h04, "R5 range low bits");
    wr(8'h04, 32'h0000_0002);
    rd(8'h04, "R5 range two");
    // R2 enable loads 2^(BASE+2)
    wr(8'h00, 32'h1);
    rd(8'h08, "R2 loaded period");
    rd(8'h00, "R2 ctrl reads one");
    rd(8'h08, "R4 count step");
    rd(8'h08, "R4 count step again");
    // R3 sticky enable
    wr(8'h00, 32'h0);
    rd(8'h00, "R3 ctrl still one");
    rd(8'h08, "R3 still counting");
    // R7 wrong restart codes
    wr(8'h0C, 32'h75);
    rd(8'h08, "R7 bad code ignored");
    wr(8'h0C, 32'h176);
    rd(8'h08, "R7 wide code ignored");
    // R5 new selection waits for reload
    wr(8'h04, 32'h0);
    rd(8'h08, "R5 no mid-count change");
    // R6 restart with new selection
    wr(8'h0C, 32'h76);
    rd(8'h08, "R6 reload to new period");
    // R8 expiry boundary
    while (cyc - load_edge < per_m - 1) @(negedge clk);
    check("R8 one before expiry", {31'b0, timeout_o}, 32'h0);
    @(negedge clk);
    check("R8 expiry", {31'b0, timeout_o}, 32'h1);
    repeat (5) @(negedge clk);
    rd(8'h08, "R8 holds zero");
    wr(8'h0C, 32'h77);
    check("R8 bad code keeps timeout", {31'b0, timeout_o}, 32'h1);
    wr(8'h0C, 32'h76);
    check("R6 restart clears timeout", {31'b0, timeout_o}, 32'h0);
    // R9 unused offsets
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h08, 32'h0000_0003);
    rd(8'h10, "R9 unused reads zero");
    rd(8'h0C, "R9 restart reads zero");
    rd(8'h05, "R9 unaligned reads zero");
    rd(8'h04, "R9 range untouched");
    rd(8'h08, "R9 count untouched");
    // R10 back-pressure
    @(posedge clk); #1 rsp_ready = 1'b0;
    @(negedge clk);
    rd(8'h00, "R10 held response");
    check("R10 ready low while held", {31'b0, req_ready}, 32'h0);
    repeat (3) @(negedge clk);
    check("R10 still valid", {31'b0, rsp_valid}, 32'h1);
    check("R10 data stable", rsp_rdata, 32'h1);
    @(posedge clk); #1 rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 no extra responses", 32'(exp_q.size()), 32'h0);
    check("R10 idle after drain", {31'b0, rsp_valid}, 32'h0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule